// File: doc/BRIEF.md
# Trigger-Gated Two-Lane Sample Streamer

This block sits between a parallel eight-lane ADC capture path and an outbound FIFO that feeds a USB bridge. In each sample-clock cycle the capture path presents all eight 14-bit lanes together with a strobe. The block keeps only lane 1 and lane 3. It sign-extends each of them to 16 bits, joins the pair into one 32-bit word, and writes that word into the FIFO. The bridge has bandwidth for two lanes only, so one word carries exactly one sample from each of the two lanes.

A host-driven, active-high gate decides which samples are valid. The gate is asynchronous to the sample clock, so it passes through a two-flop synchroniser first. A build-time option adds a hold-off that keeps the window open for a fixed number of cycles after the synchronised gate falls. The default is 30,000,000 cycles, which is 500 ms at a 60 MHz sample rate. If the gate rises again during the hold-off, the timer is cancelled and streaming carries on without a gap.

The block obeys the FIFO's full flag. A valid sample that meets a full FIFO is dropped and counted in a saturating counter, and a sticky flag records that at least one drop happened. A synchronous clear input resets both.

Top module: `trig_pair_streamer`

## Requirements
- R1: After reset, `fifo_wr` is 0, `ovf_count` is 0 and `ovf_sticky` is 0.
- R2: Lane n (n = 1..8) occupies `smp_bus[14n-1:14(n-1)]`. Only lanes 1 and 3 reach `fifo_data`. Changing any of the other six lanes has no effect on the written word.
- R3: The written word carries lane 1, sign-extended from 14 to 16 bits, in bits [15:0], and lane 3, sign-extended the same way, in bits [31:16].
- R4: While the window is closed, no word is written, whatever `smp_vld` does.
- R5: A change of `gate_in` takes effect on samples presented two clock edges later. A word that is accepted appears on `fifo_wr`/`fifo_data` one edge after its sample is presented.
- R6: With the hold-off enabled, the window stays open for exactly HOLD_CYCLES sample cycles after the synchronised gate falls.
- R7: If the gate rises again while the hold-off is running, the timer is cancelled and the window stays open without a gap.
- R8: With the hold-off disabled, the window equals the synchronised gate exactly.
- R9: A valid in-window sample presented while `fifo_full` is 1 is not written, and `ovf_count` goes up by one.
- R10: `ovf_count` saturates at 65535.
- R11: `ovf_sticky` is set by the first drop and stays set until `ovf_clear` is pulsed. `ovf_clear` also zeroes `ovf_count`, and it takes priority over a drop in the same cycle.
- R12: A cycle with `smp_vld` at 0 writes nothing and counts no drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_in | input | 1 | Asynchronous active-high streaming gate |
| smp_vld | input | 1 | Strobe marking the sample bus as holding a new sample |
| smp_bus | input | 112 | Eight 14-bit lanes, lane 1 in the low bits |
| fifo_full | input | 1 | Outbound FIFO cannot accept a word |
| ovf_clear | input | 1 | Synchronous clear of the drop counter and flag |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| fifo_data | output | 32 | Packed word: lane 3 high half, lane 1 low half |
| ovf_count | output | 16 | Saturating count of dropped samples |
| ovf_sticky | output | 1 | Set once any sample has been dropped |

## Verification
A sample presented in one cycle shows up on `fifo_wr`, `fifo_data` or `ovf_count` one edge later. A gate change reaches the samples of the cycle two edges after it. The bench drives inputs on the falling edge and reads the results of those inputs on the following falling edge. It counts gate effects from the exact falling edge at which the gate moved. This gives expected write totals over a run of cycles: 2 plus HOLD_CYCLES after a fall with the hold-off, and 2 without it. A second instance with the hold-off disabled runs on the same stimulus, so both window shapes are compared cycle for cycle.

// File: rtl/trig_stream_pkg.sv
package trig_stream_pkg;
  localparam int SMP_W  = 14;
  localparam int LANE_W = 16;
  localparam int WORD_W = 2 * LANE_W;

  function automatic logic [LANE_W-1:0] sext_lane(input logic [SMP_W-1:0] s);
    return {{(LANE_W-SMP_W){s[SMP_W-1]}}, s};
  endfunction

  function automatic logic [WORD_W-1:0] join_pair(input logic [SMP_W-1:0] lo,
                                                  input logic [SMP_W-1:0] hi);
    return {sext_lane(hi), sext_lane(lo)};
  endfunction

  function automatic logic [15:0] sat_step(input logic [15:0] v, input logic [15:0] top);
    return (v == top) ? v : v + 16'd1;
  endfunction
endpackage

// File: rtl/gate_sync.sv
module gate_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_async,
  output logic gate_lvl,
  output logic gate_rise,
  output logic gate_fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= gate_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign gate_lvl  = sync_q;
  assign gate_rise = sync_q & ~prev_q;
  assign gate_fall = ~sync_q & prev_q;
endmodule

// File: rtl/gate_window.sv
module gate_window #(
  parameter bit HOLD_EN     = 1'b1,
  parameter int HOLD_CYCLES = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_lvl,
  input  logic gate_rise,
  input  logic gate_fall,
  output logic hold_active,
  output logic window_open
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(HOLD_CYCLES - 1);

  generate
    if (HOLD_EN) begin : g_hold
      logic [CNT_W-1:0] remain_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          remain_q <= '0;
        end else if (gate_rise || gate_lvl) begin
          remain_q <= '0;
        end else if (gate_fall) begin
          remain_q <= LOAD_V;
        end else if (remain_q != '0) begin
          remain_q <= remain_q - 1'b1;
        end
      end

      assign hold_active = (remain_q != '0);
      assign window_open = gate_lvl | gate_fall | hold_active;
    end else begin : g_plain
      assign hold_active = 1'b0;
      assign window_open = gate_lvl;
    end
  endgenerate
endmodule

// File: rtl/pair_packer.sv
module pair_packer
  import trig_stream_pkg::*;
#(
  parameter int CH_COUNT = 8,
  parameter int LO_IDX   = 0,
  parameter int HI_IDX   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic [CH_COUNT*SMP_W-1:0] bus,
  output logic                      wr_q,
  output logic [WORD_W-1:0]         word_q
);
  logic [SMP_W-1:0] lane_lo, lane_hi;

  assign lane_lo = bus[LO_IDX*SMP_W +: SMP_W];
  assign lane_hi = bus[HI_IDX*SMP_W +: SMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      word_q <= '0;
    end else begin
      wr_q <= accept;
      if (accept) word_q <= join_pair(lane_lo, lane_hi);
    end
  end
endmodule

// File: rtl/drop_tally.sv
module drop_tally
  import trig_stream_pkg::*;
#(
  parameter int OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_evt,
  input  logic             clear,
  output logic [OVF_W-1:0] count_q,
  output logic             sticky_q
);
  localparam logic [15:0] TOP = 16'((64'd1 << OVF_W) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      sticky_q <= 1'b0;
    end else if (clear) begin
      count_q  <= '0;
      sticky_q <= 1'b0;
    end else if (drop_evt) begin
      count_q  <= OVF_W'(sat_step(16'(count_q), TOP));
      sticky_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_pair_streamer.sv
module trig_pair_streamer
  import trig_stream_pkg::*;
#(
  parameter int CH_COUNT    = 8,
  parameter int LO_IDX      = 0,
  parameter int HI_IDX      = 2,
  parameter bit HOLD_EN     = 1'b1,
  parameter int HOLD_CYCLES = 30_000_000,
  parameter int OVF_W       = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      gate_in,
  input  logic                      smp_vld,
  input  logic [CH_COUNT*SMP_W-1:0] smp_bus,
  input  logic                      fifo_full,
  input  logic                      ovf_clear,
  output logic                      fifo_wr,
  output logic [WORD_W-1:0]         fifo_data,
  output logic [OVF_W-1:0]          ovf_count,
  output logic                      ovf_sticky
);
  logic gate_lvl, gate_rise, gate_fall;
  logic hold_active, window_open;
  logic take_evt, drop_evt;

  gate_sync u_sync (
    .clk(clk), .rst_n(rst_n), .gate_async(gate_in),
    .gate_lvl(gate_lvl), .gate_rise(gate_rise), .gate_fall(gate_fall)
  );

  gate_window #(.HOLD_EN(HOLD_EN), .HOLD_CYCLES(HOLD_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .gate_lvl(gate_lvl), .gate_rise(gate_rise),
    .gate_fall(gate_fall), .hold_active(hold_active), .window_open(window_open)
  );

  assign take_evt = smp_vld & window_open & ~fifo_full;
  assign drop_evt = smp_vld & window_open & fifo_full;

  pair_packer #(.CH_COUNT(CH_COUNT), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)) u_pack (
    .clk(clk), .rst_n(rst_n), .accept(take_evt), .bus(smp_bus),
    .wr_q(fifo_wr), .word_q(fifo_data)
  );

  drop_tally #(.OVF_W(OVF_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .drop_evt(drop_evt), .clear(ovf_clear),
    .count_q(ovf_count), .sticky_q(ovf_sticky)
  );
endmodule

// File: rtl/trig_pair_streamer_chk.sv
module trig_pair_streamer_chk #(
  parameter int OVF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_full,
  input logic             fifo_wr,
  input logic             ovf_clear,
  input logic [OVF_W-1:0] ovf_count,
  input logic             ovf_sticky,
  input logic             window_open,
  input logic             gate_rise,
  input logic             hold_active,
  input logic             smp_vld
);
  localparam logic [OVF_W-1:0] MAXV = '1;

  a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> !fifo_wr);
  a_r4_closed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !window_open |=> !fifo_wr);
  a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !fifo_wr);
  a_r10_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count == MAXV && !ovf_clear) |=> ovf_count == MAXV);
  a_r9_count_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_clear |=> (ovf_count == $past(ovf_count) || ovf_count == $past(ovf_count) + 1'b1));
  a_r11_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clear) |=> ovf_sticky);
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |=> (ovf_count == '0 && !ovf_sticky));
  a_r7_rise_cancels_hold: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !hold_active);
endmodule

bind trig_pair_streamer trig_pair_streamer_chk #(.OVF_W(OVF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
  .ovf_clear(ovf_clear), .ovf_count(ovf_count), .ovf_sticky(ovf_sticky),
  .window_open(window_open), .gate_rise(gate_rise), .hold_active(hold_active),
  .smp_vld(smp_vld)
);

// File: tb/trig_pair_streamer_tb_top.sv
module trig_pair_streamer_tb_top;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_in = 1'b0, smp_vld = 1'b0, fifo_full = 1'b0, ovf_clear = 1'b0;
  logic [111:0] smp_bus = '0;
  logic        fifo_wr, nh_wr, nh_sticky;
  logic [31:0] fifo_data, nh_data;
  logic [15:0] ovf_count, nh_count;
  logic        ovf_sticky;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trig_pair_streamer #(.HOLD_EN(1'b1), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .smp_vld(smp_vld), .smp_bus(smp_bus),
    .fifo_full(fifo_full), .ovf_clear(ovf_clear), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .ovf_count(ovf_count), .ovf_sticky(ovf_sticky));

  trig_pair_streamer #(.HOLD_EN(1'b0), .HOLD_CYCLES(HOLD)) dut_nh_i (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .smp_vld(smp_vld), .smp_bus(smp_bus),
    .fifo_full(fifo_full), .ovf_clear(ovf_clear), .fifo_wr(nh_wr), .fifo_data(nh_data),
    .ovf_count(nh_count), .ovf_sticky(nh_sticky));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input logic [13:0] a, input logic [13:0] b);
    logic [15:0] lo, hi;
    lo = a[13] ? (16'hC000 | 16'(a)) : 16'(a);
    hi = b[13] ? (16'hC000 | 16'(b)) : 16'(b);
    return {hi, lo};
  endfunction

  function automatic logic [111:0] make_bus(input logic [13:0] l1, input logic [13:0] l3,
                                            input logic [13:0] junk);
    logic [111:0] v;
    for (int k = 0; k < 8; k++) v[k*14 +: 14] = junk ^ 14'(k * 37);
    v[13:0]  = l1;
    v[41:28] = l3;
    return v;
  endfunction

  // drive at falling edge, result visible at next falling edge
  task automatic step(input logic vld, input logic [111:0] bus);
    smp_vld = vld; smp_bus = bus;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 wr", 32'(fifo_wr), 0);
    chk("R1 count", 32'(ovf_count), 0);
    chk("R1 sticky", 32'(ovf_sticky), 0);
  endtask

  task automatic t_closed;
    step(1'b1, make_bus(14'h123, 14'h456, 14'h3AA));
    chk("R4 closed no write", 32'(fifo_wr), 0);
    chk("R4 closed no drop", 32'(ovf_count), 0);
  endtask

  task automatic t_open_pack;
    gate_in = 1'b1;
    step(1'b1, make_bus(14'h001, 14'h002, 14'h0));
    chk("R5 first edge still closed", 32'(fifo_wr), 0);
    step(1'b1, make_bus(14'h001, 14'h002, 14'h0));
    chk("R5 second edge still closed", 32'(fifo_wr), 0);
    step(1'b1, make_bus(14'h2000, 14'h1FFF, 14'h155));
    chk("R5 open after two edges", 32'(fifo_wr), 1);
    chk("R3 sign-extend pack", fifo_data, model_word(14'h2000, 14'h1FFF));
    step(1'b1, make_bus(14'h0ABC, 14'h3001, 14'h2AA));
    chk("R3 pack second", fifo_data, model_word(14'h0ABC, 14'h3001));
    step(1'b1, make_bus(14'h0ABC, 14'h3001, 14'h1C3));
    chk("R2 other lanes ignored", fifo_data, model_word(14'h0ABC, 14'h3001));
    step(1'b0, make_bus(14'h0111, 14'h0222, 14'h0));
    chk("R12 no strobe no write", 32'(fifo_wr), 0);
    chk("R12 data held", fifo_data, model_word(14'h0ABC, 14'h3001));
  endtask

  task automatic t_hold;
    int w_h = 0, w_n = 0;
    gate_in = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, make_bus(14'(i), 14'(i + 1), 14'h0));
      w_h += int'(fifo_wr); w_n += int'(nh_wr);
    end
    chk("R6 hold window writes", 32'(w_h), 32'(2 + HOLD));
    chk("R8 plain window writes", 32'(w_n), 2);
  endtask

  task automatic t_retrigger;
    int w_h = 0, w_n = 0;
    gate_in = 1'b1;
    repeat (4) step(1'b0, '0);
    gate_in = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (i == 10) gate_in = 1'b1;
      step(1'b1, make_bus(14'(i), 14'(i), 14'h0));
      w_h += int'(fifo_wr); w_n += int'(nh_wr);
    end
    chk("R7 retrigger no gap", 32'(w_h), 30);
    chk("R8 plain window gap", 32'(w_n), 20);
  endtask

  task automatic t_overflow;
    fifo_full = 1'b1;
    repeat (3) begin
      step(1'b1, make_bus(14'h7, 14'h8, 14'h0));
      chk("R9 full no write", 32'(fifo_wr), 0);
    end
    chk("R9 drops counted", 32'(ovf_count), 3);
    chk("R11 sticky set", 32'(ovf_sticky), 1);
    step(1'b0, '0);
    chk("R12 idle no drop", 32'(ovf_count), 3);
    ovf_clear = 1'b1;
    step(1'b1, make_bus(14'h7, 14'h8, 14'h0));
    ovf_clear = 1'b0;
    chk("R11 clear wins count", 32'(ovf_count), 0);
    chk("R11 clear wins sticky", 32'(ovf_sticky), 0);
    for (int i = 0; i < 65540; i++) step(1'b1, make_bus(14'h7, 14'h8, 14'h0));
    chk("R10 saturate", 32'(ovf_count), 32'hFFFF);
    fifo_full = 1'b0;
    step(1'b1, make_bus(14'h9, 14'hA, 14'h0));
    chk("R9 write after full", 32'(fifo_wr), 1);
    chk("R11 sticky persists", 32'(ovf_sticky), 1);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_closed();
    t_open_pack();
    t_hold();
    t_retrigger();
    t_overflow();
    done = 1;
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end
endmodule